// File: doc/BRIEF.md
# Tagged-Chunk Request Buffer Parser

This engine validates a request buffer that software has placed in memory before any call is executed. Given a buffer base address and a one-cycle start pulse, it fetches bytes one at a time over a simple read port. It first checks the container header. It then steps through the top-level chunks until it finds the call chunk. Along the way it captures the configuration chunk, which describes the requester's integer size, pointer size and byte order. Those values stay cached across later requests, so a buffer that omits them still parses.

At the end of a request the engine raises `done_o` for one cycle. On success it reports the call opcode and the byte offset of the call chunk header from the base address. On failure it reports a numeric protocol error code. Unknown chunks are stepped over using their length field alone. Their data bytes are never fetched. Executing the call and writing any response belong to other logic.

Top module: `rbuf_walker`

## Requirements
- R1: Bytes 0-3 must be ASCII "RIFF" and bytes 8-11 must be ASCII "SEMI". Bytes 4-7 hold a little-endian container size, and the container ends at base + size + 8. A wrong tag at either place, or a size below 4, finishes the request with error 0x02.
- R2: Each chunk is a 4-byte ASCII tag followed by a 4-byte little-endian data length. The next chunk starts at the chunk offset plus 8 plus the length, plus 1 more when the length is odd. A chunk whose tag is neither "CNFG" nor "CALL" is stepped over without fetching any of its data bytes.
- R3: Each of these finishes with error 0x01: a chunk whose padded end lies beyond the container end; fewer than 8 bytes left before the container end where a chunk header would start; reaching the container end without finding a call chunk.
- R4: A configuration chunk must have length 4. Its bytes, in order, are integer size (2, 4 or 8), pointer size (2, 4, 8 or 16), byte order (0, 1 or 2) and a zero reserved byte. Any other length or value finishes with error 0x01 and leaves the cache unchanged.
- R5: A valid configuration chunk loads the cache, shown on `cfg_valid_o` and the three cfg outputs. The cache keeps those values across later requests until another valid configuration chunk replaces them. Only reset clears it.
- R6: A call chunk met while the cache is empty finishes with error 0x03.
- R7: The call data begins with the opcode byte, followed by three reserved bytes that must be zero. A call length below 4 gives error 0x01. An opcode outside 0x01..0x31 gives error 0x04. Otherwise, any non-zero reserved byte gives error 0x01. The opcode check takes priority over the reserved-byte check.
- R8: On success `ok_o`=1, `err_o`=0, `opcode_o` is the opcode and `call_off_o` is the call chunk header offset from the base. On any error `ok_o`=0 and `opcode_o`=`call_off_o`=0.
- R9: A start pulse is taken only while `busy_o` is low; pulses while busy are ignored. `done_o` is a single-cycle pulse. The result outputs hold from one done pulse until the next.
- R10: While `mem_req_o` is high and `mem_ack_i` is low, `mem_addr_o` is held. A byte is consumed in the cycle `mem_ack_i` is high, and `mem_data_i` carries that byte. The bytes are fetched in ascending address order, exactly those the walk needs.
- R11: After reset the engine is idle: `busy_o`, `done_o`, `mem_req_o`, `ok_o`, `cfg_valid_o` are 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken when idle |
| base_i | input | AW | Buffer base address, sampled at start |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last request parsed without error |
| err_o | output | 8 | Last error code (0 on success) |
| opcode_o | output | 8 | Call opcode of last successful request |
| call_off_o | output | AW | Call chunk header offset from base |
| cfg_valid_o | output | 1 | Configuration cache holds values |
| cfg_int_o | output | 8 | Cached integer size |
| cfg_ptr_o | output | 8 | Cached pointer size |
| cfg_order_o | output | 8 | Cached byte-order code |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | AW | Byte read address |
| mem_ack_i | input | 1 | Read byte available this cycle |
| mem_data_i | input | 8 | Read byte |

## Verification
The bench targets these cases:
- An odd-length unknown chunk before the call. A design that forgets the pad byte reads the call header one byte early, loses the tag and reports the wrong offset or error 0x01.
- A huge unknown length. A design that fetches skipped data or wraps its offset arithmetic either issues unexpected reads or accepts a chunk that runs past the end.
- Opcodes 0x00, 0x31 and 0x32, plus a bad opcode combined with a non-zero reserved byte. These expose off-by-one range checks and a wrong error priority.
- A later request without a configuration chunk, a rejected configuration chunk, and a start pulse while busy. These show whether the cache is sticky, whether a bad chunk corrupts it, and whether a second start restarts the walk.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    localparam int LENW = 32;
    localparam int NTAG = 4;

    localparam int T_OUTER = 0;
    localparam int T_FORM  = 1;
    localparam int T_CFG   = 2;
    localparam int T_CALL  = 3;

    localparam logic [7:0] OPC_MIN = 8'h01;
    localparam logic [7:0] OPC_MAX = 8'h31;

    typedef enum logic [7:0] {
        E_NONE  = 8'h00,
        E_CHUNK = 8'h01,
        E_CONT  = 8'h02,
        E_NOCFG = 8'h03,
        E_OPC   = 8'h04
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_NEXT, S_CHDR, S_BODY, S_DONE
    } st_e;

    typedef enum logic [1:0] {
        K_OTHER, K_CFG, K_CALL
    } kind_e;

    typedef struct packed {
        logic [7:0] int_sz;
        logic [7:0] ptr_sz;
        logic [7:0] order;
    } cfg_t;

    // fourCC words with the first ASCII character in bits [7:0]
    function automatic logic [31:0] tag_word(input int k);
        case (k)
            T_OUTER: return 32'h4646_4952;
            T_FORM:  return 32'h494D_4553;
            T_CFG:   return 32'h4746_4E43;
            default: return 32'h4C4C_4143;
        endcase
    endfunction

    function automatic logic int_ok(input logic [7:0] b);
        return (b == 8'd2) || (b == 8'd4) || (b == 8'd8);
    endfunction

    function automatic logic ptr_ok(input logic [7:0] b);
        return (b == 8'd2) || (b == 8'd4) || (b == 8'd8) || (b == 8'd16);
    endfunction

    function automatic logic ord_ok(input logic [7:0] b);
        return b <= 8'd2;
    endfunction

    function automatic logic opc_ok(input logic [7:0] b);
        return (b >= OPC_MIN) && (b <= OPC_MAX);
    endfunction

endpackage

// File: rtl/rbuf_tag_track.sv
module rbuf_tag_track
    import rbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_v,
    input  logic [1:0]      idx,
    input  logic [7:0]      byte_i,
    output logic [NTAG-1:0] hit_o
);
    // hit_o[k] is high when bytes 0..idx (current byte included) match tag k
    for (genvar k = 0; k < NTAG; k++) begin : g_tag
        localparam logic [31:0] W = tag_word(k);
        logic run_q;
        logic eq;

        always_comb eq = (byte_i == W[8*idx +: 8]);
        assign hit_o[k] = eq && ((idx == 2'd0) || run_q);

        always_ff @(posedge clk) begin
            if (rst)         run_q <= 1'b0;
            else if (byte_v) run_q <= hit_o[k];
        end
    end
endmodule

// File: rtl/rbuf_span.sv
module rbuf_span #(
    parameter int OW = 34
) (
    input  logic [OW-1:0] pos_i,
    input  logic [OW-1:0] end_i,
    input  logic [31:0]   len_i,
    output logic [OW-1:0] nxt_o,
    output logic          at_end_o,
    output logic          hdr_short_o,
    output logic          overrun_o
);
    // offsets carry two extra bits so a full 32-bit length cannot wrap
    assign nxt_o       = pos_i + OW'(8) + OW'(len_i) + OW'(len_i[0]);
    assign at_end_o    = (pos_i == end_i);
    assign hdr_short_o = (pos_i + OW'(8)) > end_i;
    assign overrun_o   = nxt_o > end_i;
endmodule

// File: rtl/rbuf_cfg_cache.sv
module rbuf_cfg_cache
    import rbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_v,
    input  logic [1:0] idx,
    input  logic [7:0] byte_i,
    input  logic       commit_i,
    output logic       ok_now_o,
    output logic       valid_o,
    output cfg_t       cfg_o
);
    cfg_t sh_q;
    logic bad_q;
    logic bad_now;

    always_comb begin
        case (idx)
            2'd0:    bad_now = !int_ok(byte_i);
            2'd1:    bad_now = bad_q || !ptr_ok(byte_i);
            2'd2:    bad_now = bad_q || !ord_ok(byte_i);
            default: bad_now = bad_q || (byte_i != 8'h00);
        endcase
    end
    assign ok_now_o = !bad_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bad_q   <= 1'b0;
            valid_o <= 1'b0;
            cfg_o   <= '0;
        end else begin
            if (byte_v) begin
                bad_q <= bad_now;
                case (idx)
                    2'd0:    sh_q.int_sz <= byte_i;
                    2'd1:    sh_q.ptr_sz <= byte_i;
                    2'd2:    sh_q.order  <= byte_i;
                    default: ;
                endcase
            end
            if (commit_i) begin
                cfg_o   <= sh_q;
                valid_o <= 1'b1;
            end
        end
    end

    a_r5_cache_sticky: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);

    a_r4_cache_legal: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (int_ok(cfg_o.int_sz) && ptr_ok(cfg_o.ptr_sz) && ord_ok(cfg_o.order)));
endmodule

// File: rtl/rbuf_walker.sv
module rbuf_walker
    import rbuf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          ok_o,
    output logic [7:0]    err_o,
    output logic [7:0]    opcode_o,
    output logic [AW-1:0] call_off_o,
    output logic          cfg_valid_o,
    output logic [7:0]    cfg_int_o,
    output logic [7:0]    cfg_ptr_o,
    output logic [7:0]    cfg_order_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [7:0]    mem_data_i
);
    localparam int OW = LENW + 2;

    st_e            st_q;
    kind_e          kind_q;
    logic [3:0]     cnt_q;
    logic [AW-1:0]  base_q;
    logic [OW-1:0]  pos_q, end_q;
    logic [31:0]    len_q, len_now, span_len;
    logic           riff_q, rsv_q, rsv_all;
    logic [7:0]     opc_q;
    logic           take, fin, cfg_ok_now, cfg_commit;
    err_e           fin_code;
    logic [NTAG-1:0] hit;
    logic [OW-1:0]  nxt;
    logic           at_end, hdr_short, overrun;
    cfg_t           cfg;

    assign mem_req_o  = (st_q == S_HDR) || (st_q == S_CHDR) || (st_q == S_BODY);
    assign mem_addr_o = base_q + AW'(pos_q) + AW'(cnt_q);
    assign take       = mem_req_o && mem_ack_i;
    assign busy_o     = (st_q != S_IDLE);
    assign done_o     = (st_q == S_DONE);
    assign len_now    = {mem_data_i, len_q[31:8]};
    assign span_len   = (st_q == S_CHDR) ? len_now : len_q;
    assign rsv_all    = rsv_q || (mem_data_i != 8'h00);
    assign cfg_commit = take && (st_q == S_BODY) && (kind_q == K_CFG)
                        && (cnt_q == 4'd11) && cfg_ok_now;

    rbuf_tag_track u_tags (
        .clk(clk), .rst(rst), .byte_v(take), .idx(cnt_q[1:0]),
        .byte_i(mem_data_i), .hit_o(hit)
    );

    rbuf_span #(.OW(OW)) u_span (
        .pos_i(pos_q), .end_i(end_q), .len_i(span_len), .nxt_o(nxt),
        .at_end_o(at_end), .hdr_short_o(hdr_short), .overrun_o(overrun)
    );

    rbuf_cfg_cache u_cfg (
        .clk(clk), .rst(rst),
        .byte_v(take && (st_q == S_BODY) && (kind_q == K_CFG)),
        .idx(cnt_q[1:0]), .byte_i(mem_data_i), .commit_i(cfg_commit),
        .ok_now_o(cfg_ok_now), .valid_o(cfg_valid_o), .cfg_o(cfg)
    );

    assign cfg_int_o   = cfg.int_sz;
    assign cfg_ptr_o   = cfg.ptr_sz;
    assign cfg_order_o = cfg.order;

    // termination decisions and their error codes, in priority order
    always_comb begin
        fin      = 1'b0;
        fin_code = E_NONE;
        if (st_q == S_NEXT && (at_end || hdr_short)) begin
            fin = 1'b1; fin_code = E_CHUNK;
        end else if (take) begin
            case (st_q)
                S_HDR: if (cnt_q == 4'd11 && (!riff_q || !hit[T_FORM] || len_q < 32'd4)) begin
                    fin = 1'b1; fin_code = E_CONT;
                end
                S_CHDR: if (cnt_q == 4'd7) begin
                    if (overrun) begin
                        fin = 1'b1; fin_code = E_CHUNK;
                    end else if (kind_q == K_CFG && len_now != 32'd4) begin
                        fin = 1'b1; fin_code = E_CHUNK;
                    end else if (kind_q == K_CALL && !cfg_valid_o) begin
                        fin = 1'b1; fin_code = E_NOCFG;
                    end else if (kind_q == K_CALL && len_now < 32'd4) begin
                        fin = 1'b1; fin_code = E_CHUNK;
                    end
                end
                S_BODY: if (cnt_q == 4'd11) begin
                    if (kind_q == K_CFG) begin
                        if (!cfg_ok_now) begin fin = 1'b1; fin_code = E_CHUNK; end
                    end else begin
                        fin = 1'b1;
                        if (!opc_ok(opc_q))  fin_code = E_OPC;
                        else if (rsv_all)    fin_code = E_CHUNK;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            kind_q     <= K_OTHER;
            cnt_q      <= '0;
            base_q     <= '0;
            pos_q      <= '0;
            end_q      <= '0;
            len_q      <= '0;
            riff_q     <= 1'b0;
            rsv_q      <= 1'b0;
            opc_q      <= '0;
            ok_o       <= 1'b0;
            err_o      <= '0;
            opcode_o   <= '0;
            call_off_o <= '0;
        end else begin
            if (take) cnt_q <= cnt_q + 4'd1;
            if (fin) begin
                st_q       <= S_DONE;
                ok_o       <= (fin_code == E_NONE);
                err_o      <= fin_code;
                opcode_o   <= (fin_code == E_NONE) ? opc_q : 8'h00;
                call_off_o <= (fin_code == E_NONE) ? AW'(pos_q) : '0;
            end else begin
                case (st_q)
                    S_IDLE: if (start_i) begin
                        st_q   <= S_HDR;
                        base_q <= base_i;
                        pos_q  <= '0;
                        cnt_q  <= '0;
                    end
                    S_HDR: if (take) begin
                        if (cnt_q == 4'd3) riff_q <= hit[T_OUTER];
                        if (cnt_q >= 4'd4 && cnt_q <= 4'd7) len_q <= len_now;
                        if (cnt_q == 4'd11) begin
                            end_q <= OW'(len_q) + OW'(8);
                            pos_q <= OW'(12);
                            st_q  <= S_NEXT;
                        end
                    end
                    S_NEXT: begin
                        cnt_q <= '0;
                        st_q  <= S_CHDR;
                    end
                    S_CHDR: if (take) begin
                        if (cnt_q == 4'd3)
                            kind_q <= hit[T_CFG]  ? K_CFG :
                                      hit[T_CALL] ? K_CALL : K_OTHER;
                        if (cnt_q >= 4'd4) len_q <= len_now;
                        if (cnt_q == 4'd7) begin
                            if (kind_q == K_OTHER) begin
                                pos_q <= nxt;
                                st_q  <= S_NEXT;
                            end else begin
                                st_q  <= S_BODY;
                            end
                        end
                    end
                    S_BODY: if (take) begin
                        if (cnt_q == 4'd8) begin
                            opc_q <= mem_data_i;
                            rsv_q <= 1'b0;
                        end else begin
                            rsv_q <= rsv_all;
                        end
                        if (cnt_q == 4'd11) begin
                            pos_q <= nxt;
                            st_q  <= S_NEXT;
                        end
                    end
                    S_DONE:  st_q <= S_IDLE;
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r8_ok_result: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> (err_o == 8'h00 && opcode_o >= OPC_MIN && opcode_o <= OPC_MAX));

    a_r3_err_known: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ok_o) |-> (err_o == 8'h01 || err_o == 8'h02 || err_o == 8'h03 || err_o == 8'h04));

    a_r6_ok_needs_cfg: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> cfg_valid_o);
endmodule

// File: tb/rbuf_walker_tb_top.sv
module rbuf_walker_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic          busy, done, ok, cfg_v, mem_req;
    logic [7:0]    err, opc, cfg_int, cfg_ptr, cfg_ord;
    logic [AW-1:0] off, mem_addr;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_data = '0;

    always #2 clk = ~clk;

    rbuf_walker #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .base_i(base),
        .busy_o(busy), .done_o(done), .ok_o(ok), .err_o(err),
        .opcode_o(opc), .call_off_o(off), .cfg_valid_o(cfg_v),
        .cfg_int_o(cfg_int), .cfg_ptr_o(cfg_ptr), .cfg_order_o(cfg_ord),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_ack_i(mem_ack), .mem_data_i(mem_data)
    );

    int checks = 0;
    int failures = 0;

    logic [7:0] mem [0:511];
    int slow = 0;
    int gap = 0;

    // byte memory: one-cycle ack, optional idle gap after each ack
    always @(posedge clk) begin
        if (mem_req && !mem_ack && gap == 0) begin
            mem_ack  <= 1'b1;
            mem_data <= mem[mem_addr[8:0]];
            gap      <= slow;
        end else begin
            mem_ack <= 1'b0;
            if (gap > 0) gap <= gap - 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    longint exp_q[$];
    bit     m_cfg_v = 0;
    int     m_int = 0, m_ptr = 0, m_ord = 0;
    bit     e_ok;
    int     e_err, e_opc;
    longint e_off;

    function automatic int bv(input longint a);
        return int'(mem[int'(a & 511)]);
    endfunction

    function automatic longint le32(input longint a);
        return longint'(bv(a)) | (longint'(bv(a+1)) << 8) |
               (longint'(bv(a+2)) << 16) | (longint'(bv(a+3)) << 24);
    endfunction

    function automatic bit tag_at(input longint a, input string s);
        for (int i = 0; i < 4; i++) if (bv(a+i) != int'(s[i])) return 0;
        return 1;
    endfunction

    task automatic push_rng(input longint a, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back((a + i) & 64'hFFFF_FFFF);
    endtask

    task automatic model(input longint b);
        longint pos, endp, len, nxt;
        int op, i0, p0, o0;
        exp_q.delete();
        e_ok = 0; e_opc = 0; e_off = 0; e_err = 0;
        push_rng(b, 12);
        if (!tag_at(b, "RIFF") || !tag_at(b+8, "SEMI") || le32(b+4) < 4) begin e_err = 2; return; end
        endp = le32(b+4) + 8;
        pos  = 12;
        while (1) begin
            if (pos == endp || pos + 8 > endp) begin e_err = 1; return; end
            push_rng(b+pos, 8);
            len = le32(b+pos+4);
            nxt = pos + 8 + len + (len % 2);
            if (nxt > endp) begin e_err = 1; return; end
            if (tag_at(b+pos, "CNFG")) begin
                if (len != 4) begin e_err = 1; return; end
                push_rng(b+pos+8, 4);
                i0 = bv(b+pos+8); p0 = bv(b+pos+9); o0 = bv(b+pos+10);
                if (!(i0 == 2 || i0 == 4 || i0 == 8) || !(p0 == 2 || p0 == 4 || p0 == 8 || p0 == 16)
                    || o0 > 2 || bv(b+pos+11) != 0) begin e_err = 1; return; end
                m_cfg_v = 1; m_int = i0; m_ptr = p0; m_ord = o0;
                pos = nxt;
            end else if (tag_at(b+pos, "CALL")) begin
                if (!m_cfg_v) begin e_err = 3; return; end
                if (len < 4) begin e_err = 1; return; end
                push_rng(b+pos+8, 4);
                op = bv(b+pos+8);
                if (op < 1 || op > 'h31) begin e_err = 4; return; end
                if (bv(b+pos+9) != 0 || bv(b+pos+10) != 0 || bv(b+pos+11) != 0) begin e_err = 1; return; end
                e_ok = 1; e_opc = op; e_off = pos;
                return;
            end else begin
                pos = nxt;
            end
        end
    endtask

    // every consumed byte compared against the model's address stream
    always @(negedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (exp_q.size() == 0) chk("R10", "unexpected read", longint'(mem_addr), -1);
            else                   chk("R10", "read address", longint'(mem_addr), exp_q.pop_front());
        end
    end

    // ---------------- buffer builder ----------------
    longint cur;
    task automatic w8(input int v);  mem[int'(cur & 511)] = 8'(v); cur++; endtask
    task automatic w32(input longint v); for (int i = 0; i < 4; i++) w8(int'((v >> (8*i)) & 255)); endtask
    task automatic wtag(input string s); for (int i = 0; i < 4; i++) w8(int'(s[i])); endtask
    task automatic open_buf(input longint b, input string outer, input string form);
        cur = b; wtag(outer); w32(0); wtag(form);
    endtask
    task automatic close_buf(input longint b);
        longint save;
        save = cur; cur = b + 4; w32(save - b - 8); cur = save;
    endtask
    task automatic cfg_chunk(input int i0, input int p0, input int o0, input int r0);
        wtag("CNFG"); w32(4); w8(i0); w8(p0); w8(o0); w8(r0);
    endtask
    task automatic call_chunk(input int op, input int rsv);
        wtag("CALL"); w32(4); w8(op); w8(0); w8(rsv); w8(0);
    endtask

    // ---------------- request runner ----------------
    task automatic run(input longint b, input int hand_err, input string req, input bit intrude);
        int n;
        model(b);
        chk(req, "model agrees with hand value", e_err, hand_err);
        @(negedge clk); start = 1'b1; base = AW'(b);
        @(negedge clk); start = 1'b0;
        chk("R9", "busy after start", busy, 1);
        if (intrude) begin
            @(negedge clk); @(negedge clk);
            start = 1'b1; base = AW'(b + 100);
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(req, "error code", err, e_err);
        chk("R8", "ok flag", ok, e_ok);
        chk("R8", "opcode", opc, e_opc);
        chk("R8", "call offset", longint'(off), e_off);
        chk("R5", "cfg valid", cfg_v, m_cfg_v);
        if (m_cfg_v) begin
            chk("R5", "cfg int", cfg_int, m_int);
            chk("R5", "cfg ptr", cfg_ptr, m_ptr);
            chk("R5", "cfg order", cfg_ord, m_ord);
        end
        chk("R10", "all expected bytes read", exp_q.size(), 0);
        @(negedge clk);
        chk("R9", "done is one cycle", done, 0);
        chk("R9", "result held", err, e_err);
        chk("R9", "idle after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "mem_req", mem_req, 0);
        chk("R11", "ok", ok, 0);
        chk("R11", "err", err, 0);
        chk("R11", "cfg_valid", cfg_v, 0);

        // R6: call before any configuration
        open_buf(32'h20, "RIFF", "SEMI"); call_chunk(8'h05, 0); close_buf(32'h20);
        run(32'h20, 3, "R6", 0);

        // R1: bad outer tag, bad form tag, size below 4
        open_buf(32'h20, "RIFX", "SEMI"); call_chunk(8'h05, 0); close_buf(32'h20);
        run(32'h20, 2, "R1", 0);
        open_buf(32'h20, "RIFF", "SEMX"); call_chunk(8'h05, 0); close_buf(32'h20);
        run(32'h20, 2, "R1", 0);
        open_buf(32'h20, "RIFF", "SEMI"); call_chunk(8'h05, 0); close_buf(32'h20);
        cur = 32'h24; w32(3);
        run(32'h20, 2, "R1", 0);

        // R4: illegal pointer size, then wrong length; cache stays empty
        open_buf(32'h30, "RIFF", "SEMI"); cfg_chunk(2, 3, 0, 0); call_chunk(8'h05, 0); close_buf(32'h30);
        run(32'h30, 1, "R4", 0);
        open_buf(32'h30, "RIFF", "SEMI");
        wtag("CNFG"); w32(6); w8(2); w8(2); w8(0); w8(0); w8(0); w8(0);
        call_chunk(8'h05, 0); close_buf(32'h30);
        run(32'h30, 1, "R4", 0);

        // R2 R8: odd unknown chunk with pad, long call, high base bits
        open_buf(64'h1000_0040, "RIFF", "SEMI"); cfg_chunk(2, 2, 0, 0);
        wtag("JUNK"); w32(5); w8(1); w8(2); w8(3); w8(4); w8(5); w8(0);
        wtag("CALL"); w32(12); w8(8'h05); w8(0); w8(0); w8(0);
        for (int i = 0; i < 8; i++) w8(8'h11);
        close_buf(64'h1000_0040);
        run(64'h1000_0040, 0, "R2", 0);
        chk("R8", "offset value", longint'(off), 38);

        // R5 R7: cached configuration, top opcode
        open_buf(32'h80, "RIFF", "SEMI"); call_chunk(8'h31, 0); close_buf(32'h80);
        run(32'h80, 0, "R5", 0);

        // R7: opcode just above range, zero opcode, reserved byte, priority
        open_buf(32'h80, "RIFF", "SEMI"); call_chunk(8'h32, 0); close_buf(32'h80);
        run(32'h80, 4, "R7", 0);
        open_buf(32'h80, "RIFF", "SEMI"); call_chunk(8'h00, 0); close_buf(32'h80);
        run(32'h80, 4, "R7", 0);
        open_buf(32'h80, "RIFF", "SEMI"); call_chunk(8'h10, 8'h7F); close_buf(32'h80);
        run(32'h80, 1, "R7", 0);
        open_buf(32'h80, "RIFF", "SEMI"); call_chunk(8'h40, 8'h7F); close_buf(32'h80);
        run(32'h80, 4, "R7", 0);
        open_buf(32'h80, "RIFF", "SEMI"); wtag("CALL"); w32(3); w8(8'h05); w8(0); w8(0); w8(0);
        close_buf(32'h80);
        run(32'h80, 1, "R7", 0);

        // R3: huge unknown length, container without call, trailing short header
        open_buf(32'h100, "RIFF", "SEMI"); wtag("JUNK"); w32(64'hFFFF_FFF0); call_chunk(8'h05, 0);
        close_buf(32'h100);
        run(32'h100, 1, "R3", 0);
        open_buf(32'h100, "RIFF", "SEMI"); cfg_chunk(4, 8, 1, 0); close_buf(32'h100);
        run(32'h100, 1, "R3", 0);
        open_buf(32'h100, "RIFF", "SEMI"); cfg_chunk(4, 4, 0, 0); w32(0); close_buf(32'h100);
        run(32'h100, 1, "R3", 0);

        // R2: zero-length unknown chunk then a call
        open_buf(32'h140, "RIFF", "SEMI"); wtag("ABCD"); w32(0); call_chunk(8'h01, 0); close_buf(32'h140);
        run(32'h140, 0, "R2", 0);
        chk("R2", "offset after empty chunk", longint'(off), 20);

        // R9 R10: slow memory and a start pulse while busy
        slow = 2;
        open_buf(32'h1C0, "RIFF", "SEMI"); cfg_chunk(8, 16, 2, 0); call_chunk(8'h18, 0); close_buf(32'h1C0);
        run(32'h1C0, 0, "R9", 1);
        slow = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule